// File: doc/BRIEF.md
# Event Counter Bank

This block is a bank of hardware event counters for a shared cache slice. Up to 256 single-bit event lines enter the block, and each counter picks one of them with an 8-bit event code. On every clock where the selected line is high and counting is allowed, the counter adds one. Counting is allowed only when the bank-wide run bit and the counter's own enable bit are both set. Two optional qualifiers can narrow what is counted. The first is a 2-bit channel match, which applies only to a window of ring-traffic event codes. The second is a trace-tag gate.

Software reaches the block over a simple single-cycle register bus. Control registers are 32 bits wide and the counters are 64 bits wide. When a counter wraps past its largest value, it sets a sticky status bit. That bit is cleared by writing a one to a separate clear register. A single interrupt line is raised while any status bit is not masked. Read data is combinational from the current address, so it is valid in the same cycle.

Top module: `evcnt_bank`

## Requirements
- R1: After synchronous reset, all counters, per-counter enables, the run bit, the filter and tag fields, the event codes and the status bits are zero. The mask register at 0x0800 reads all ones, and irq is low.
- R2: The control register is at 0x1C00. Counter n adds exactly 1 on each clock where its selected event line is high, control bit n is 1 and control bit 26 (global run) is 1. If either bit is 0, the counter holds its value.
- R3: Event codes live in two 32-bit registers at 0x1D00 and 0x1D04. The code for counter n is in register n/4, bits 8*(n mod 4)+7 down to 8*(n mod 4), and both registers read back as written.
- R4: Counter n is read and written as one 64-bit word at 0x1E00 + 8*n. A bus write to a counter wins over an increment in the same cycle.
- R5: Control bits 28:27 hold a channel filter. When it is nonzero, a counter whose code lies in 0x47..0x59 (both ends included) counts only in cycles where ev_chan equals the filter. Codes outside that window ignore the filter.
- R6: When control bit 29 is 1, counting happens only in cycles where ev_tag is 1.
- R7: When counter n is incremented from all ones, it wraps to zero and sets status bit n, readable at 0x0808. Writes to 0x0808 have no effect.
- R8: Writing a 1 to bit n at 0x080C clears status bit n. Bits written as 0 leave status unchanged, and 0x080C reads as zero.
- R9: Mask bit n = 1 blocks status bit n from the interrupt. irq is the OR of the status bits whose mask bit is 0.
- R10: The read-only register at 0x1CF0 returns the VERSION parameter, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| addr | input | 16 | Byte address for reads and writes |
| wdata | input | 64 | Write data; control registers use bits 31:0 |
| rdata | output | 64 | Read data for addr, combinational |
| ev_in | input | 256 | Event lines, indexed by event code |
| ev_chan | input | 2 | Channel tag of this cycle's ring events |
| ev_tag | input | 1 | Trace-tag qualifier of this cycle's events |
| irq | output | 1 | Overflow interrupt |

## Verification
The counting path is tested in several ways:
- An event is pulsed with only the run bit set, then with only the per-counter bit set, then with both. This separates the two enables.
- Codes are placed in different byte lanes of the second select register. This shows which lane feeds which counter.
- The channel filter runs with codes 0x46, 0x47, 0x59, 0x5A, 0x50 and 0x10 at once, first with a mismatched channel and then with a matching one. This checks both window edges and that codes outside the window are unaffected.
- Counters preloaded near all ones, together with mask and clear sequences, show the wrap, the sticky status, the write-one-to-clear behaviour and the masking of the interrupt.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;

    localparam int ADDR_W  = 16;
    localparam int CODE_W  = 8;
    localparam int NUM_EV  = 1 << CODE_W;
    localparam int CHAN_W  = 2;

    // Register offsets
    localparam logic [ADDR_W-1:0] OFS_MASK = 16'h0800;
    localparam logic [ADDR_W-1:0] OFS_STAT = 16'h0808;
    localparam logic [ADDR_W-1:0] OFS_CLR  = 16'h080C;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 16'h1C00;
    localparam logic [ADDR_W-1:0] OFS_VER  = 16'h1CF0;
    localparam logic [ADDR_W-1:0] OFS_SEL  = 16'h1D00;
    localparam logic [ADDR_W-1:0] OFS_CNT  = 16'h1E00;

    // Control word field positions
    localparam int CTL_RUN_BIT = 26;
    localparam int CTL_CHN_LO  = 27;
    localparam int CTL_TAG_BIT = 29;

    // Event codes that honour the channel filter
    localparam logic [CODE_W-1:0] WIN_LO = 8'h47;
    localparam logic [CODE_W-1:0] WIN_HI = 8'h59;

    typedef struct packed {
        logic              tag_gate;
        logic [CHAN_W-1:0] chan;
        logic              run;
    } mode_t;

    typedef enum logic [2:0] {
        RS_NONE,
        RS_MASK,
        RS_STAT,
        RS_CLR,
        RS_CTRL,
        RS_VER,
        RS_SEL,
        RS_CNT
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e   sel;
        logic [3:0] idx;
    } dec_t;

    function automatic logic in_window(input logic [CODE_W-1:0] code);
        return (code >= WIN_LO) && (code <= WIN_HI);
    endfunction

    function automatic dec_t decode(input logic [ADDR_W-1:0] a);
        dec_t d;
        d.sel = RS_NONE;
        d.idx = '0;
        if (a == OFS_MASK)      d.sel = RS_MASK;
        else if (a == OFS_STAT) d.sel = RS_STAT;
        else if (a == OFS_CLR)  d.sel = RS_CLR;
        else if (a == OFS_CTRL) d.sel = RS_CTRL;
        else if (a == OFS_VER)  d.sel = RS_VER;
        else if (a[ADDR_W-1:3] == OFS_SEL[ADDR_W-1:3] && a[1:0] == 2'b00) begin
            d.sel = RS_SEL;
            d.idx = {3'b000, a[2]};
        end
        else if (a[ADDR_W-1:6] == OFS_CNT[ADDR_W-1:6] && a[2:0] == 3'b000) begin
            d.sel = RS_CNT;
            d.idx = {1'b0, a[5:3]};
        end
        return d;
    endfunction

endpackage

// File: rtl/evcnt_regs.sv
module evcnt_regs
    import evcnt_pkg::*;
#(
    parameter int NUM_CNT = 8
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  dec_t                            dec,
    input  logic [31:0]                     wdata,
    output logic [NUM_CNT-1:0]              en_q,
    output mode_t                           mode_q,
    output logic [NUM_CNT-1:0][CODE_W-1:0]  code_q,
    output logic [NUM_CNT-1:0]              mask_q,
    output logic [31:0]                     ctrl_word,
    output logic [1:0][31:0]                sel_word
);

    logic wr_ctrl, wr_mask, wr_sel;

    assign wr_ctrl = wr_en && (dec.sel == RS_CTRL);
    assign wr_mask = wr_en && (dec.sel == RS_MASK);
    assign wr_sel  = wr_en && (dec.sel == RS_SEL);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            mode_q <= '0;
        end else if (wr_ctrl) begin
            en_q            <= wdata[NUM_CNT-1:0];
            mode_q.run      <= wdata[CTL_RUN_BIT];
            mode_q.chan     <= wdata[CTL_CHN_LO +: CHAN_W];
            mode_q.tag_gate <= wdata[CTL_TAG_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          mask_q <= '1;
        else if (wr_mask) mask_q <= wdata[NUM_CNT-1:0];
    end

    for (genvar n = 0; n < NUM_CNT; n++) begin : g_code
        always_ff @(posedge clk) begin
            if (rst)
                code_q[n] <= '0;
            else if (wr_sel && dec.idx == 4'(n / 4))
                code_q[n] <= wdata[CODE_W*(n % 4) +: CODE_W];
        end
    end

    for (genvar k = 0; k < 2; k++) begin : g_selw
        for (genvar b = 0; b < 4; b++) begin : g_lane
            if (4 * k + b < NUM_CNT) begin : g_used
                assign sel_word[k][CODE_W*b +: CODE_W] = code_q[4*k+b];
            end else begin : g_pad
                assign sel_word[k][CODE_W*b +: CODE_W] = '0;
            end
        end
    end

    always_comb begin
        ctrl_word                        = '0;
        ctrl_word[NUM_CNT-1:0]           = en_q;
        ctrl_word[CTL_RUN_BIT]           = mode_q.run;
        ctrl_word[CTL_CHN_LO +: CHAN_W]  = mode_q.chan;
        ctrl_word[CTL_TAG_BIT]           = mode_q.tag_gate;
    end

    a_r1_mask_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> mask_q == '1);

    a_r2_enables_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_ctrl |=> $stable(en_q) && $stable(mode_q));

endmodule

// File: rtl/evcnt_slice.sv
module evcnt_slice
    import evcnt_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_EV-1:0] ev_in,
    input  logic [CHAN_W-1:0] ev_chan,
    input  logic              ev_tag,
    input  logic [CODE_W-1:0] code,
    input  logic              en,
    input  mode_t             mode,
    input  logic              wr_hit,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              ovf
);

    logic hit, chan_ok, tag_ok, inc;

    assign hit     = ev_in[code];
    assign chan_ok = (mode.chan == '0) || !in_window(code) || (ev_chan == mode.chan);
    assign tag_ok  = !mode.tag_gate || ev_tag;
    assign inc     = mode.run && en && hit && chan_ok && tag_ok;

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (wr_hit) cnt_q <= wdata;
        else if (inc)    cnt_q <= cnt_q + 1'b1;
    end

    assign ovf = inc && !wr_hit && (&cnt_q);

    a_r4_write_wins: assert property (@(posedge clk) disable iff (rst)
        wr_hit |=> cnt_q == $past(wdata));

    a_r2_run_gate: assert property (@(posedge clk) disable iff (rst)
        (!mode.run || !en) && !wr_hit |=> $stable(cnt_q));

    a_r5_chan_block: assert property (@(posedge clk) disable iff (rst)
        (mode.chan != '0) && in_window(code) && (ev_chan != mode.chan) && !wr_hit
        |=> $stable(cnt_q));

endmodule

// File: rtl/evcnt_irq.sv
module evcnt_irq #(
    parameter int NUM_CNT = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_CNT-1:0] ovf,
    input  logic [NUM_CNT-1:0] clr,
    input  logic [NUM_CNT-1:0] mask,
    output logic [NUM_CNT-1:0] status_q,
    output logic               irq
);

    // A wrap in the same cycle as a clear keeps the bit set
    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= (status_q & ~clr) | ovf;
    end

    assign irq = |(status_q & ~mask);

    for (genvar n = 0; n < NUM_CNT; n++) begin : g_chk
        a_r7_wrap_sets: assert property (@(posedge clk) disable iff (rst)
            ovf[n] |=> status_q[n]);

        a_r8_w1c: assert property (@(posedge clk) disable iff (rst)
            clr[n] && !ovf[n] |=> !status_q[n]);
    end

endmodule

// File: rtl/evcnt_bank.sv
module evcnt_bank
    import evcnt_pkg::*;
#(
    parameter int          NUM_CNT = 8,
    parameter int          CNT_W   = 64,
    parameter logic [31:0] VERSION = 32'h0005_0001
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [CNT_W-1:0]    wdata,
    output logic [CNT_W-1:0]    rdata,
    input  logic [NUM_EV-1:0]   ev_in,
    input  logic [CHAN_W-1:0]   ev_chan,
    input  logic                ev_tag,
    output logic                irq
);

    localparam int IDX_W = $clog2(NUM_CNT);

    dec_t                           dec;
    logic [NUM_CNT-1:0]             en_q;
    mode_t                          mode_q;
    logic [NUM_CNT-1:0][CODE_W-1:0] code_q;
    logic [NUM_CNT-1:0]             mask_q;
    logic [31:0]                    ctrl_word;
    logic [1:0][31:0]               sel_word;
    logic [NUM_CNT-1:0][CNT_W-1:0]  cnt;
    logic [NUM_CNT-1:0]             ovf;
    logic [NUM_CNT-1:0]             clr;
    logic [NUM_CNT-1:0]             status;

    assign dec = decode(addr);
    assign clr = (wr_en && dec.sel == RS_CLR) ? wdata[NUM_CNT-1:0] : '0;

    evcnt_regs #(.NUM_CNT(NUM_CNT)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .dec       (dec),
        .wdata     (wdata[31:0]),
        .en_q      (en_q),
        .mode_q    (mode_q),
        .code_q    (code_q),
        .mask_q    (mask_q),
        .ctrl_word (ctrl_word),
        .sel_word  (sel_word)
    );

    for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
        logic wr_hit;
        assign wr_hit = wr_en && (dec.sel == RS_CNT) && (dec.idx == 4'(n));

        evcnt_slice #(.CNT_W(CNT_W)) u_slice (
            .clk     (clk),
            .rst     (rst),
            .ev_in   (ev_in),
            .ev_chan (ev_chan),
            .ev_tag  (ev_tag),
            .code    (code_q[n]),
            .en      (en_q[n]),
            .mode    (mode_q),
            .wr_hit  (wr_hit),
            .wdata   (wdata),
            .cnt_q   (cnt[n]),
            .ovf     (ovf[n])
        );
    end

    evcnt_irq #(.NUM_CNT(NUM_CNT)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .ovf      (ovf),
        .clr      (clr),
        .mask     (mask_q),
        .status_q (status),
        .irq      (irq)
    );

    always_comb begin
        rdata = '0;
        case (dec.sel)
            RS_MASK: rdata[NUM_CNT-1:0] = mask_q;
            RS_STAT: rdata[NUM_CNT-1:0] = status;
            RS_CTRL: rdata[31:0]        = ctrl_word;
            RS_VER:  rdata[31:0]        = VERSION;
            RS_SEL:  rdata[31:0]        = sel_word[dec.idx[0]];
            RS_CNT:  if (dec.idx < 4'(NUM_CNT)) rdata = cnt[dec.idx[IDX_W-1:0]];
            default: rdata = '0;
        endcase
    end

    a_r9_all_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '1) |-> !irq);

endmodule

// File: tb/evcnt_bank_test.sv
`timescale 1ns/1ps
module evcnt_bank_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [15:0]  addr = '0;
    logic [63:0]  wdata = '0;
    logic [63:0]  rdata;
    logic [255:0] ev_in = '0;
    logic [1:0]   ev_chan = '0;
    logic         ev_tag = 1'b0;
    logic         irq;

    int checks = 0;
    int errors = 0;

    localparam logic [63:0] RUN  = 64'h1 << 26;
    localparam logic [63:0] TAGB = 64'h1 << 29;
    localparam logic [63:0] ONES = '1;

    evcnt_bank uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ev_in(ev_in), .ev_chan(ev_chan), .ev_tag(ev_tag), .irq(irq)
    );

    always #2.5 clk = ~clk;

    function automatic logic [15:0] cnt_a(input int n);
        return 16'h1E00 + 16'(8 * n);
    endfunction

    function automatic logic [255:0] ev(input logic [7:0] c);
        logic [255:0] v = '0;
        v[c] = 1'b1;
        return v;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [63:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic pulse(input logic [255:0] v, input int n, input logic [1:0] ch, input logic tg);
        @(negedge clk);
        ev_in = v; ev_chan = ch; ev_tag = tg;
        repeat (n) @(negedge clk);
        ev_in = '0;
    endtask

    task automatic t_reset;
        logic [63:0] d;
        rd(16'h0800, d); chk("R1 mask reset", d, 64'hFF);
        rd(16'h1C00, d); chk("R1 ctrl reset", d, 64'h0);
        rd(16'h0808, d); chk("R1 status reset", d, 64'h0);
        rd(cnt_a(0), d); chk("R1 counter0 reset", d, 64'h0);
        rd(16'h1D04, d); chk("R1 select reset", d, 64'h0);
        chk("R1 irq reset", {63'b0, irq}, 64'h0);
    endtask

    task automatic t_enables;
        logic [63:0] d;
        wr(16'h1D00, 64'h0000_0005);
        wr(16'h1C00, 64'h1);
        pulse(ev(8'h05), 4, 2'd0, 1'b0);
        rd(cnt_a(0), d); chk("R2 no run bit", d, 64'd0);
        wr(16'h1C00, RUN);
        pulse(ev(8'h05), 4, 2'd0, 1'b0);
        rd(cnt_a(0), d); chk("R2 no counter enable", d, 64'd0);
        wr(16'h1C00, RUN | 64'h1);
        pulse(ev(8'h05), 6, 2'd0, 1'b0);
        rd(cnt_a(0), d); chk("R2 both enables", d, 64'd6);
    endtask

    task automatic t_lanes;
        logic [63:0] d;
        wr(16'h1D04, 64'h0000_2021);
        rd(16'h1D04, d); chk("R3 select readback", d, 64'h2021);
        wr(16'h1C00, RUN | 64'h30);
        pulse(ev(8'h20), 3, 2'd0, 1'b0);
        rd(cnt_a(5), d); chk("R3 lane1 counter5", d, 64'd3);
        rd(cnt_a(4), d); chk("R3 lane0 counter4 idle", d, 64'd0);
        pulse(ev(8'h21), 2, 2'd0, 1'b0);
        rd(cnt_a(4), d); chk("R3 lane0 counter4", d, 64'd2);
    endtask

    task automatic t_chan;
        logic [63:0] d;
        logic [255:0] v;
        wr(16'h1D00, 64'h5A46_5947);
        wr(16'h1D04, 64'h0000_1050);
        for (int n = 0; n < 6; n++) wr(cnt_a(n), 64'd0);
        wr(16'h1C00, RUN | 64'h3F | (64'd2 << 27));
        v = ev(8'h47) | ev(8'h59) | ev(8'h46) | ev(8'h5A) | ev(8'h50) | ev(8'h10);
        pulse(v, 4, 2'd1, 1'b0);
        pulse(v, 3, 2'd2, 1'b0);
        rd(cnt_a(0), d); chk("R5 window low edge 0x47", d, 64'd3);
        rd(cnt_a(1), d); chk("R5 window high edge 0x59", d, 64'd3);
        rd(cnt_a(2), d); chk("R5 below window 0x46", d, 64'd7);
        rd(cnt_a(3), d); chk("R5 above window 0x5A", d, 64'd7);
        rd(cnt_a(4), d); chk("R5 inside window 0x50", d, 64'd3);
        rd(cnt_a(5), d); chk("R5 unrelated code 0x10", d, 64'd7);
    endtask

    task automatic t_tag;
        logic [63:0] d;
        wr(cnt_a(0), 64'd0);
        wr(16'h1C00, RUN | TAGB | 64'h1);
        pulse(ev(8'h47), 3, 2'd3, 1'b0);
        pulse(ev(8'h47), 2, 2'd3, 1'b1);
        rd(cnt_a(0), d); chk("R6 tag gate", d, 64'd2);
    endtask

    task automatic t_prio;
        logic [63:0] d;
        wr(16'h1C00, RUN | 64'h1);
        @(negedge clk);
        ev_in = ev(8'h47); ev_tag = 1'b0;
        repeat (3) @(negedge clk);
        wr(cnt_a(0), 64'd100);
        rd(cnt_a(0), d); chk("R4 write beats increment", d, 64'd100);
        @(negedge clk);
        rd(cnt_a(0), d); chk("R4 counting resumes", d, 64'd101);
        ev_in = '0;
        wr(cnt_a(7), 64'h1234_5678_9ABC_DEF0);
        rd(cnt_a(7), d); chk("R4 64-bit readback", d, 64'h1234_5678_9ABC_DEF0);
    endtask

    task automatic t_ovf;
        logic [63:0] d;
        logic [255:0] v;
        v = ev(8'h46) | ev(8'h5A);
        wr(16'h1C00, RUN | 64'h0C);
        wr(16'h0800, 64'hF7);
        wr(cnt_a(2), ONES);
        wr(cnt_a(3), ONES - 64'd1);
        pulse(v, 1, 2'd0, 1'b0);
        rd(cnt_a(2), d); chk("R7 wrap to zero", d, 64'd0);
        rd(cnt_a(3), d); chk("R7 no wrap below max", d, ONES);
        rd(16'h0808, d); chk("R7 status after wrap", d, 64'h04);
        chk("R9 masked wrap keeps irq low", {63'b0, irq}, 64'h0);
        pulse(v, 1, 2'd0, 1'b0);
        rd(16'h0808, d); chk("R7 second wrap", d, 64'h0C);
        chk("R9 unmasked wrap raises irq", {63'b0, irq}, 64'h1);
        wr(16'h0808, 64'h0);
        rd(16'h0808, d); chk("R7 status ignores writes", d, 64'h0C);
    endtask

    task automatic t_clear;
        logic [63:0] d;
        wr(16'h1C00, 64'h0);
        wr(16'h080C, 64'h0);
        rd(16'h0808, d); chk("R8 zero write no effect", d, 64'h0C);
        chk("R8 irq still high", {63'b0, irq}, 64'h1);
        wr(16'h080C, 64'h08);
        rd(16'h0808, d); chk("R8 clear bit3", d, 64'h04);
        chk("R9 irq low after clear", {63'b0, irq}, 64'h0);
        rd(16'h080C, d); chk("R8 clear reg reads zero", d, 64'h0);
        wr(16'h0800, 64'hFB);
        chk("R9 unmask bit2", {63'b0, irq}, 64'h1);
        wr(16'h080C, 64'h04);
        rd(16'h0808, d); chk("R8 all cleared", d, 64'h0);
        chk("R9 irq low", {63'b0, irq}, 64'h0);
    endtask

    task automatic t_version;
        logic [63:0] d;
        rd(16'h1CF0, d); chk("R10 version", d, 64'h0005_0001);
        wr(16'h1CF0, 64'hFFFF_FFFF);
        rd(16'h1CF0, d); chk("R10 version read-only", d, 64'h0005_0001);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_enables();
        t_lanes();
        t_chan();
        t_tag();
        t_prio();
        t_ovf();
        t_clear();
        t_version();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #500000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule